// File: doc/BRIEF.md
# Transceiver power-up and cable-detach supervisor

This block decides when a coaxial transceiver may pass traffic and whether its host-side line drivers are actively driven. It watches three inputs: a supply-low flag from the voltage monitor, an already synchronized flag that reports the coax input sitting near the supply rail (cable unplugged), and a strap that mutes the detach announcement. From these it drives a transceiver enable that lifts the forced transmit/receive squelch, a high-impedance control for the host drivers (so two attachment paths can share wiring and the cable that is plugged in decides which one is used), and a level request to the collision signalling logic.

All waits are counted in clock cycles. The power-up wait, the detach qualification time and the announcement length are parameters. A shift parameter divides all three by a power of two, which keeps simulations short. Each scaled count is clamped to at least one. Timing in the requirements uses "samples": the input values seen at successive rising clock edges. Outputs change on the edge that takes the deciding sample.

Top module: `xcvr_supervisor`

## Requirements
- R1: While `rst_n` is low, and on every edge that samples `supply_low` high, the block returns to its power-up wait: `xcvr_enable` and `host_drv_hiz` are 0 from that edge on.
- R2: In the power-up wait, `xcvr_enable` rises on the PU-th consecutive sample with `supply_low` low, where PU = max(1, POWERUP_CYCLES >> SIM_SHIFT); before that it stays 0.
- R3: Leaving the power-up wait never raises `coll_announce`, even when `coax_off` is already high at that moment.
- R4: While enabled, `coax_off` sampled high on DT+1 consecutive edges (DT = max(1, DETACH_CYCLES >> SIM_SHIFT)) drops `xcvr_enable` and raises `host_drv_hiz` on that edge. A single low sample restarts the count.
- R5: The edge of R4 also raises `coll_announce`, and it stays high for exactly AN = max(1, ANNOUNCE_CYCLES >> SIM_SHIFT) cycles unless R8 cuts it short.
- R6: If `announce_mute` is sampled high on the edge of R4, no announcement starts.
- R7: In the detached state, the first sample of `coax_off` low clears `host_drv_hiz` and sets `xcvr_enable` on that edge. No announcement starts, and one already running continues to its end.
- R8: An edge that samples `supply_low` high clears `coll_announce` from that edge on, and it also resets the detach count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Undervoltage indication |
| coax_off | input | 1 | Synchronized cable-detached indication |
| announce_mute | input | 1 | Suppresses the detach announcement |
| xcvr_enable | output | 1 | Releases the forced transmit/receive squelch |
| host_drv_hiz | output | 1 | Host line drivers to high impedance |
| coll_announce | output | 1 | Collision announcement request (level) |

## Verification
The interesting coincidences are a supply dip that lands inside a running announcement, and a re-attach that falls within the announcement window. In the first case the dip must win and silence the request on the same edge. In the second case the request must continue while the enable comes back. Directed sequences place the dip and the re-attach a few cycles into a burst. Biased random traffic then holds `coax_off` within a few cycles of the qualification threshold and mixes in short supply dips. Every cycle is compared against a bench model written from the requirements.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [1:0] {
      SUP_WAIT = 2'd0,
      SUP_LIVE = 2'd1,
      SUP_CUT  = 2'd2
   } sup_state_e;

   // divide a raw cycle count by 2**shift, never below one cycle
   function automatic int unsigned scaled(input int unsigned raw, input int unsigned shift);
      int unsigned v;
      v = raw >> shift;
      return (v == 0) ? 1 : v;
   endfunction

   // counter width able to hold values 0 .. n-1
   function automatic int unsigned cbits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sup_run_ctr.sv
// Saturating run counter: hit is high on the LIMIT-th consecutive inc sample.
module sup_run_ctr #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int unsigned W = sup_pkg::cbits(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sup_run_ctr: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit = inc && !clr && (cnt_q == LAST);

endmodule

// File: rtl/sup_burst.sv
// Fixed-length level pulse: fire loads LEN, kill clears, counts down otherwise.
module sup_burst #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic fire,
   output logic active
);
   localparam int unsigned W = sup_pkg::cbits(LEN + 1);
   localparam logic [W-1:0] LOAD = W'(LEN);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("sup_burst: LEN must be at least 1");
      end
   endgenerate

   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (kill) begin
         left_q <= '0;
      end else if (fire) begin
         left_q <= LOAD;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign active = (left_q != '0);

endmodule

// File: rtl/sup_seq.sv
// Three-state supervisor sequence: wait after power-up, live, cable cut.
module sup_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic coax_off,
   input  logic announce_mute,
   input  logic pu_hit,
   input  logic det_hit,
   output sup_pkg::sup_state_e state,
   output logic fire,
   output logic enable,
   output logic hiz
);
   import sup_pkg::*;

   sup_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      fire    = 1'b0;
      if (supply_low) begin
         state_d = SUP_WAIT;
      end else begin
         unique case (state_q)
            SUP_WAIT: if (pu_hit) state_d = SUP_LIVE;
            SUP_LIVE: if (det_hit) begin
               state_d = SUP_CUT;
               fire    = !announce_mute;
            end
            SUP_CUT:  if (!coax_off) state_d = SUP_LIVE;
            default:  state_d = SUP_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SUP_WAIT;
      else        state_q <= state_d;
   end

   assign state  = state_q;
   assign enable = (state_q == SUP_LIVE);
   assign hiz    = (state_q == SUP_CUT);

endmodule

// File: rtl/xcvr_supervisor.sv
module xcvr_supervisor #(
   parameter int unsigned POWERUP_CYCLES  = 4_000_000,
   parameter int unsigned DETACH_CYCLES   = 8_000_000,
   parameter int unsigned ANNOUNCE_CYCLES = 4_000_000,
   parameter int unsigned SIM_SHIFT       = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic coax_off,
   input  logic announce_mute,
   output logic xcvr_enable,
   output logic host_drv_hiz,
   output logic coll_announce
);
   import sup_pkg::*;

   localparam int unsigned PU_N = scaled(POWERUP_CYCLES, SIM_SHIFT);
   localparam int unsigned DT_N = scaled(DETACH_CYCLES, SIM_SHIFT);
   localparam int unsigned AN_N = scaled(ANNOUNCE_CYCLES, SIM_SHIFT);

   generate
      if (SIM_SHIFT > 31) begin : g_bad_shift
         $error("xcvr_supervisor: SIM_SHIFT too large");
      end
      if (DT_N >= 32'hFFFF_FFFF) begin : g_bad_detach
         $error("xcvr_supervisor: DETACH_CYCLES too large");
      end
   endgenerate

   sup_state_e state;
   logic pu_hit, det_hit, fire;

   // power-up wait: consecutive supply-good samples spent in the wait state
   sup_run_ctr #(.LIMIT(PU_N)) u_pu_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (supply_low || (state != SUP_WAIT)),
      .inc   (state == SUP_WAIT),
      .hit   (pu_hit)
   );

   // detach qualification: strictly more than DT_N continuous samples
   sup_run_ctr #(.LIMIT(DT_N + 1)) u_det_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (supply_low || !coax_off),
      .inc   (coax_off),
      .hit   (det_hit)
   );

   sup_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_low    (supply_low),
      .coax_off      (coax_off),
      .announce_mute (announce_mute),
      .pu_hit        (pu_hit),
      .det_hit       (det_hit),
      .state         (state),
      .fire          (fire),
      .enable        (xcvr_enable),
      .hiz           (host_drv_hiz)
   );

   sup_burst #(.LEN(AN_N)) u_announce (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (supply_low),
      .fire   (fire),
      .active (coll_announce)
   );

endmodule

// File: rtl/xcvr_supervisor_chk.sv
module xcvr_supervisor_chk #(
   parameter int unsigned POWERUP_CYCLES  = 4_000_000,
   parameter int unsigned DETACH_CYCLES   = 8_000_000,
   parameter int unsigned ANNOUNCE_CYCLES = 4_000_000,
   parameter int unsigned SIM_SHIFT       = 0
) (
   input logic clk,
   input logic rst_n,
   input logic supply_low,
   input logic coax_off,
   input logic announce_mute,
   input logic xcvr_enable,
   input logic host_drv_hiz,
   input logic coll_announce
);
   localparam int unsigned PU_N = sup_pkg::scaled(POWERUP_CYCLES, SIM_SHIFT);
   localparam int unsigned DT_N = sup_pkg::scaled(DETACH_CYCLES, SIM_SHIFT);
   localparam int unsigned AN_N = sup_pkg::scaled(ANNOUNCE_CYCLES, SIM_SHIFT);

   int unsigned wait_run, det_run, ann_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_run <= 0;
         det_run  <= 0;
         ann_run  <= 0;
      end else begin
         wait_run <= (supply_low || xcvr_enable || host_drv_hiz) ? 0 : wait_run + 1;
         det_run  <= (supply_low || !coax_off) ? 0 :
                     (det_run == 32'hFFFF_FFFF) ? det_run : det_run + 1;
         ann_run  <= !coll_announce ? 0 :
                     (ann_run == 32'hFFFF_FFFF) ? ann_run : ann_run + 1;
      end
   end

   p_squelch_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |=> (!xcvr_enable && !host_drv_hiz));

   p_wait_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xcvr_enable) && !$past(host_drv_hiz)) |-> (wait_run >= PU_N));

   p_announce_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coll_announce) |-> (host_drv_hiz && $past(xcvr_enable)));

   p_detach_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_drv_hiz) |-> (det_run >= DT_N + 1));

   p_announce_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(coll_announce) |-> ($past(supply_low) || (ann_run >= AN_N)));

   p_mute_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(host_drv_hiz) && $past(announce_mute) && !$past(coll_announce)) |-> !coll_announce);

   p_reattach_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_drv_hiz && !coax_off && !supply_low) |=> (xcvr_enable && !host_drv_hiz));

   p_low_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low |=> !coll_announce);

endmodule

bind xcvr_supervisor xcvr_supervisor_chk #(
   .POWERUP_CYCLES  (POWERUP_CYCLES),
   .DETACH_CYCLES   (DETACH_CYCLES),
   .ANNOUNCE_CYCLES (ANNOUNCE_CYCLES),
   .SIM_SHIFT       (SIM_SHIFT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .supply_low    (supply_low),
   .coax_off      (coax_off),
   .announce_mute (announce_mute),
   .xcvr_enable   (xcvr_enable),
   .host_drv_hiz  (host_drv_hiz),
   .coll_announce (coll_announce)
);

// File: tb/xcvr_supervisor_test.sv
module xcvr_supervisor_test;
   localparam int CLK_PERIOD = 10;
   localparam int unsigned PU_RAW = 400;
   localparam int unsigned DT_RAW = 800;
   localparam int unsigned AN_RAW = 400;
   localparam int unsigned SHIFT  = 3;

   function automatic int unsigned shrink(input int unsigned raw, input int unsigned sh);
      int unsigned v;
      v = raw >> sh;
      return (v == 0) ? 1 : v;
   endfunction

   localparam int unsigned PU = shrink(PU_RAW, SHIFT);
   localparam int unsigned DT = shrink(DT_RAW, SHIFT);
   localparam int unsigned AN = shrink(AN_RAW, SHIFT);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low = 1'b0;
   logic coax_off = 1'b0;
   logic announce_mute = 1'b0;
   logic xcvr_enable, host_drv_hiz, coll_announce;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xcvr_supervisor #(
      .POWERUP_CYCLES  (PU_RAW),
      .DETACH_CYCLES   (DT_RAW),
      .ANNOUNCE_CYCLES (AN_RAW),
      .SIM_SHIFT       (SHIFT)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_low    (supply_low),
      .coax_off      (coax_off),
      .announce_mute (announce_mute),
      .xcvr_enable   (xcvr_enable),
      .host_drv_hiz  (host_drv_hiz),
      .coll_announce (coll_announce)
   );

   // reference model built from the requirements: 0 wait, 1 live, 2 cut
   int unsigned m_st = 0, m_pu = 0, m_det = 0, m_ann = 0;

   always @(posedge clk) begin
      bit dhit;
      if (!rst_n || supply_low) begin
         m_st = 0; m_pu = 0; m_det = 0; m_ann = 0;          // R1, R8
      end else begin
         dhit  = coax_off && (m_det >= DT);                 // R4
         m_det = coax_off ? ((m_det < DT) ? m_det + 1 : m_det) : 0;
         if (m_ann != 0) m_ann = m_ann - 1;
         case (m_st)
            0: if (m_pu >= PU - 1) begin m_st = 1; m_pu = 0; end  // R2, R3
               else m_pu = m_pu + 1;
            1: if (dhit) begin
                  m_st = 2;
                  if (!announce_mute) m_ann = AN;            // R5, R6
               end
            default: if (!coax_off) m_st = 1;               // R7
         endcase
      end
   end

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check_bit("R2 model xcvr_enable", xcvr_enable, m_st == 1);
         check_bit("R4 model host_drv_hiz", host_drv_hiz, m_st == 2);
         check_bit("R5 model coll_announce", coll_announce, m_ann != 0);
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog all requirements actual=%0d cycles expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic tick(input int unsigned n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      tick(3);
      check_bit("R1 reset enable", xcvr_enable, 1'b0);
      check_bit("R1 reset hiz", host_drv_hiz, 1'b0);
      check_bit("R1 reset announce", coll_announce, 1'b0);
      rst_n = 1'b1;

      // R2: power-up wait length
      tick(PU - 1);
      check_bit("R2 still waiting", xcvr_enable, 1'b0);
      tick(1);
      check_bit("R2 enabled", xcvr_enable, 1'b1);
      check_bit("R3 no power-up announce", coll_announce, 1'b0);

      // R4: short detach restarts the qualification
      coax_off = 1'b1; tick(DT);
      check_bit("R4 not yet detached", host_drv_hiz, 1'b0);
      coax_off = 1'b0; tick(1);
      coax_off = 1'b1; tick(DT);
      check_bit("R4 restarted count", host_drv_hiz, 1'b0);
      tick(1);
      check_bit("R4 detached hiz", host_drv_hiz, 1'b1);
      check_bit("R4 detached enable", xcvr_enable, 1'b0);
      check_bit("R5 announce starts", coll_announce, 1'b1);
      tick(AN - 1);
      check_bit("R5 announce last cycle", coll_announce, 1'b1);
      tick(1);
      check_bit("R5 announce ended", coll_announce, 1'b0);

      // R7: re-attach, no announcement
      coax_off = 1'b0; tick(1);
      check_bit("R7 reattach enable", xcvr_enable, 1'b1);
      check_bit("R7 reattach hiz", host_drv_hiz, 1'b0);
      check_bit("R7 reattach silent", coll_announce, 1'b0);

      // R7: re-attach inside a running announcement
      coax_off = 1'b1; tick(DT + 1);
      check_bit("R5 second announce", coll_announce, 1'b1);
      tick(5);
      coax_off = 1'b0; tick(1);
      check_bit("R7 enable during burst", xcvr_enable, 1'b1);
      check_bit("R7 burst continues", coll_announce, 1'b1);
      tick(AN);
      check_bit("R5 burst finished", coll_announce, 1'b0);

      // R6: muted detach
      announce_mute = 1'b1; coax_off = 1'b1; tick(DT + 1);
      check_bit("R6 muted hiz", host_drv_hiz, 1'b1);
      check_bit("R6 muted silent", coll_announce, 1'b0);
      coax_off = 1'b0; announce_mute = 1'b0; tick(1);
      check_bit("R7 back live", xcvr_enable, 1'b1);

      // R8: supply dip inside an announcement, cable stays off
      coax_off = 1'b1; tick(DT + 1);
      check_bit("R5 third announce", coll_announce, 1'b1);
      supply_low = 1'b1; tick(1);
      check_bit("R8 announce cut", coll_announce, 1'b0);
      check_bit("R1 dip enable", xcvr_enable, 1'b0);
      check_bit("R1 dip hiz", host_drv_hiz, 1'b0);
      tick(3);
      supply_low = 1'b0; tick(PU);
      check_bit("R2 re-enabled after dip", xcvr_enable, 1'b1);
      check_bit("R3 no announce on power-up", coll_announce, 1'b0);
      tick(DT + 1 - PU);
      check_bit("R4 detach after dip", host_drv_hiz, 1'b1);
      check_bit("R5 announce after dip", coll_announce, 1'b1);
      coax_off = 1'b0; tick(1);

      // constrained random phase, model compared every cycle
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         r = $urandom % 16;
         if (r == 0) begin
            supply_low = 1'b1; tick(1 + $urandom % 4);
            supply_low = 1'b0;
         end else if (r < 5) begin
            announce_mute = $urandom % 3 == 0;
            coax_off = 1'b1; tick(DT - 2 + $urandom % 5);
            coax_off = 1'b0; tick(1 + $urandom % 3);
         end else begin
            coax_off = $urandom % 2;
            announce_mute = $urandom % 4 == 0;
            tick(1 + $urandom % (2 * PU));
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule